// File: doc/BRIEF.md
# Chained Byte Stream Cipher

This block holds two byte-serial cipher lanes, one that scrambles and one that unscrambles, for a lightweight command channel. Each lane takes one byte on every cycle its valid input is high and returns the transformed byte one cycle later. Every byte is mixed with two 8-bit chaining registers using modulo-256 addition, subtraction and XOR against fixed constants. Because of this chaining, the same plaintext byte gives a different ciphertext depending on the bytes that came before it in the packet.

A packet-start pulse reloads both chaining registers to their seed values, so no packet depends on the one before it. The start pulse may arrive on its own or in the same cycle as the first byte. The scrambling lane feeds back its own output byte and its input byte. The unscrambling lane feeds back its recovered byte and its incoming ciphertext byte. As a result, the two lanes stay in step, and any packet of 1 to 64 bytes comes back unchanged after passing through both.

Top module: `chained_byte_cipher`

## Requirements
- R1: A synchronous active-high reset clears both output valid flags and loads both chaining registers with their seeds (A = 0x9B, B = 0x54). A byte 0x00 sent after reset with no start pulse scrambles to 0xDA.
- R2: The scrambling lane computes `t = (((v ^ B ^ 0x2B) - 0x05) ^ 0x35) - 0x39` and `out = (((t ^ A ^ 0x5A) - 0xB0) ^ 0x38) - 0x45`, with all arithmetic modulo 256.
- R3: After each byte it accepts, the scrambling lane sets B to the output byte and A to the input byte.
- R4: The unscrambling lane computes `t = ((((c + 0x45) ^ 0x38) + 0xB0) ^ 0x5A) ^ A` and `out = ((((t + 0x39) ^ 0x35) + 0x05) ^ 0x2B) ^ B`, with all arithmetic modulo 256.
- R5: After each byte it accepts, the unscrambling lane sets A to the recovered byte and B to the input ciphertext byte.
- R6: When the start pulse and a valid byte arrive in the same cycle, that byte is transformed using the seed values, whatever state came before.
- R7: Each output valid is high in exactly the cycles that follow a cycle in which the matching input valid was high.
- R8: In a cycle with input valid low, the lane's chaining state and its output data do not change.
- R9: A start pulse with input valid low reloads the seeds, so the next byte sent without a start pulse uses the seed values.
- R10: Passing any packet of 1 to 64 bytes through the scrambling lane and then the unscrambling lane gives back the original bytes.
- R11: The two lanes are independent, and both may accept a byte in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_in_valid | input | 1 | Scrambling lane: input byte valid |
| enc_in_start | input | 1 | Scrambling lane: packet start, reloads the seeds |
| enc_in_data | input | 8 | Scrambling lane: plaintext byte |
| enc_out_valid | output | 1 | Scrambling lane: output byte valid |
| enc_out_data | output | 8 | Scrambling lane: ciphertext byte |
| dec_in_valid | input | 1 | Unscrambling lane: input byte valid |
| dec_in_start | input | 1 | Unscrambling lane: packet start, reloads the seeds |
| dec_in_data | input | 8 | Unscrambling lane: ciphertext byte |
| dec_out_valid | output | 1 | Unscrambling lane: output byte valid |
| dec_out_data | output | 8 | Unscrambling lane: recovered plaintext byte |

## Verification
The two functions that can fall in the same cycle are the reload of the seeds by a start pulse and the chaining update caused by a valid byte. The bench provokes this by starting a new packet with a byte in the cycle right after the last byte of the previous packet. It also inserts a lone start pulse in the middle of a stream. In each case the bench checks that the byte is transformed with the seeds (0x00 must give 0xDA), rather than with the chained state or a mix of the two. It also drives both lanes in the same cycles and checks that every random packet survives the round trip.

// File: rtl/cipher_pkg.sv
package cipher_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        byte_t a;
        byte_t b;
    } chain_state_t;

    localparam chain_state_t SEED = '{a: 8'h9B, b: 8'h54};

    // Forward mixing: two rounds, the first keyed by b, the second by a.
    function automatic byte_t scramble(input byte_t v, input chain_state_t s);
        byte_t t;
        t = (((v ^ s.b ^ 8'h2B) - 8'h05) ^ 8'h35) - 8'h39;
        return (((t ^ s.a ^ 8'h5A) - 8'hB0) ^ 8'h38) - 8'h45;
    endfunction

    // Inverse mixing: undoes the rounds in reverse order.
    function automatic byte_t unscramble(input byte_t c, input chain_state_t s);
        byte_t t;
        t = ((((c + 8'h45) ^ 8'h38) + 8'hB0) ^ 8'h5A) ^ s.a;
        return ((((t + 8'h39) ^ 8'h35) + 8'h05) ^ 8'h2B) ^ s.b;
    endfunction
endpackage

// File: rtl/cipher_chain_reg.sv
module cipher_chain_reg
    import cipher_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         reseed,
    input  logic         advance,
    input  chain_state_t next_state,
    output chain_state_t cur_state
);
    always_ff @(posedge clk) begin
        if (rst || reseed)
            cur_state <= SEED;
        else if (advance)
            cur_state <= next_state;
    end
endmodule

// File: rtl/cipher_lane.sv
module cipher_lane
    import cipher_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  logic  in_start,
    input  byte_t in_data,
    output logic  out_valid,
    output byte_t out_data
);
    chain_state_t cur_state, eff_state, next_state;
    byte_t        result;

    // A start in the same cycle as a byte overrides the held state.
    assign eff_state = in_start ? SEED : cur_state;

    generate
        if (INVERSE) begin : g_inv
            always_comb begin
                result       = unscramble(in_data, eff_state);
                next_state.a = result;
                next_state.b = in_data;
            end
        end else begin : g_fwd
            always_comb begin
                result       = scramble(in_data, eff_state);
                next_state.a = in_data;
                next_state.b = result;
            end
        end
    endgenerate

    cipher_chain_reg u_chain (
        .clk        (clk),
        .rst        (rst),
        .reseed     (in_start && !in_valid),
        .advance    (in_valid),
        .next_state (next_state),
        .cur_state  (cur_state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_data <= result;
        end
    end
endmodule

// File: rtl/chained_byte_cipher.sv
module chained_byte_cipher
    import cipher_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enc_in_valid,
    input  logic       enc_in_start,
    input  logic [7:0] enc_in_data,
    output logic       enc_out_valid,
    output logic [7:0] enc_out_data,
    input  logic       dec_in_valid,
    input  logic       dec_in_start,
    input  logic [7:0] dec_in_data,
    output logic       dec_out_valid,
    output logic [7:0] dec_out_data
);
    cipher_lane #(.INVERSE(1'b0)) u_fwd (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (enc_in_valid),
        .in_start  (enc_in_start),
        .in_data   (enc_in_data),
        .out_valid (enc_out_valid),
        .out_data  (enc_out_data)
    );

    cipher_lane #(.INVERSE(1'b1)) u_inv (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (dec_in_valid),
        .in_start  (dec_in_start),
        .in_data   (dec_in_data),
        .out_valid (dec_out_valid),
        .out_data  (dec_out_data)
    );
endmodule

// File: rtl/chained_byte_cipher_chk.sv
module chained_byte_cipher_chk (
    input logic       clk,
    input logic       rst,
    input logic       enc_in_valid,
    input logic       enc_in_start,
    input logic [7:0] enc_in_data,
    input logic       enc_out_valid,
    input logic [7:0] enc_out_data,
    input logic       dec_in_valid,
    input logic       dec_in_start,
    input logic [7:0] dec_in_data,
    input logic       dec_out_valid,
    input logic [7:0] dec_out_data
);
    a_r7_enc_latency: assert property (@(posedge clk) disable iff (rst)
        enc_in_valid |=> enc_out_valid);
    a_r7_enc_quiet: assert property (@(posedge clk) disable iff (rst)
        !enc_in_valid |=> !enc_out_valid);
    a_r7_dec_latency: assert property (@(posedge clk) disable iff (rst)
        dec_in_valid |=> dec_out_valid);
    a_r7_dec_quiet: assert property (@(posedge clk) disable iff (rst)
        !dec_in_valid |=> !dec_out_valid);
    a_r8_enc_hold: assert property (@(posedge clk) disable iff (rst)
        !enc_in_valid |=> $stable(enc_out_data));
    a_r8_dec_hold: assert property (@(posedge clk) disable iff (rst)
        !dec_in_valid |=> $stable(dec_out_data));
    a_r6_enc_seeded: assert property (@(posedge clk) disable iff (rst)
        (enc_in_valid && enc_in_start && enc_in_data == 8'h00) |=> enc_out_data == 8'hDA);
    a_r6_dec_seeded: assert property (@(posedge clk) disable iff (rst)
        (dec_in_valid && dec_in_start && dec_in_data == 8'hDA) |=> dec_out_data == 8'h00);
endmodule

bind chained_byte_cipher chained_byte_cipher_chk u_chk (.*);

// File: tb/tb_chained_byte_cipher.sv
module tb_chained_byte_cipher;
    logic       clk = 1'b0;
    logic       rst;
    logic       enc_in_valid, enc_in_start, dec_in_valid, dec_in_start;
    logic [7:0] enc_in_data, dec_in_data;
    logic       enc_out_valid, dec_out_valid;
    logic [7:0] enc_out_data, dec_out_data;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #4 clk = ~clk;

    chained_byte_cipher dut (.*);

    // Bench model state for each lane, derived from the requirements.
    logic [7:0] ea, eb, da, db;

    function automatic logic [7:0] m_enc(input logic [7:0] v, input logic [7:0] a, input logic [7:0] b);
        logic [7:0] t;
        t = (((v ^ b ^ 8'h2B) - 8'h05) ^ 8'h35) - 8'h39;
        return (((t ^ a ^ 8'h5A) - 8'hB0) ^ 8'h38) - 8'h45;
    endfunction

    function automatic logic [7:0] m_dec(input logic [7:0] c, input logic [7:0] a, input logic [7:0] b);
        logic [7:0] t;
        t = ((((c + 8'h45) ^ 8'h38) + 8'hB0) ^ 8'h5A) ^ a;
        return ((((t + 8'h39) ^ 8'h35) + 8'h05) ^ 8'h2B) ^ b;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One cycle on both lanes: drive at negedge, sample just after posedge.
    task automatic step(input bit es, input bit ev, input logic [7:0] ed,
                        input bit ds, input bit dv, input logic [7:0] dd);
        @(negedge clk);
        enc_in_start = es; enc_in_valid = ev; enc_in_data = ed;
        dec_in_start = ds; dec_in_valid = dv; dec_in_data = dd;
        @(posedge clk);
        #1;
    endtask

    task automatic model_reset();
        ea = 8'h9B; eb = 8'h54; da = 8'h9B; db = 8'h54;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        enc_in_valid = 0; enc_in_start = 0; enc_in_data = 0;
        dec_in_valid = 0; dec_in_start = 0; dec_in_data = 0;
        @(posedge clk); @(posedge clk); #1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // Send one scrambling byte, check against model; returns ciphertext.
    task automatic enc_byte(input bit s, input logic [7:0] v, input string req, output logic [7:0] c);
        logic [7:0] exp;
        if (s) begin ea = 8'h9B; eb = 8'h54; end
        exp = m_enc(v, ea, eb);
        ea = v; eb = exp;
        step(s, 1'b1, v, 1'b0, 1'b0, 8'h00);
        check(enc_out_valid === 1'b1, "R7", int'(enc_out_valid), 1);
        check(enc_out_data === exp, req, int'(enc_out_data), int'(exp));
        c = enc_out_data;
    endtask

    task automatic dec_byte(input bit s, input logic [7:0] c, input logic [7:0] plain, input string req);
        logic [7:0] exp;
        if (s) begin da = 8'h9B; db = 8'h54; end
        exp = m_dec(c, da, db);
        da = exp; db = c;
        step(1'b0, 1'b0, 8'h00, s, 1'b1, c);
        check(dec_out_valid === 1'b1, "R7", int'(dec_out_valid), 1);
        check(dec_out_data === exp, req, int'(dec_out_data), int'(exp));
        check(dec_out_data === plain, "R10", int'(dec_out_data), int'(plain));
    endtask

    // Directed vector table: {start, plaintext}.
    localparam logic [8:0] VEC [12] = '{
        9'h100, 9'h0FF, 9'h055, 9'h0AA, 9'h001, 9'h180,
        9'h07F, 9'h000, 9'h100, 9'h100, 9'h0C3, 9'h03C
    };

    logic [7:0] cbuf [64];
    logic [7:0] pbuf [64];

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] c, held;
        do_reset();

        // R1: reset state
        check(enc_out_valid === 1'b0, "R1", int'(enc_out_valid), 0);
        check(dec_out_valid === 1'b0, "R1", int'(dec_out_valid), 0);
        enc_byte(1'b0, 8'h00, "R1", c);
        check(c === 8'hDA, "R1", int'(c), 'hDA);

        // Vector table walk through the scrambling lane (R2, R3, R6)
        foreach (VEC[i]) begin
            enc_byte(VEC[i][8], VEC[i][7:0], "R2", c);
            cbuf[i] = c;
        end
        // Same table through the unscrambling lane (R4, R5, R10)
        foreach (VEC[i]) dec_byte(VEC[i][8], cbuf[i], VEC[i][7:0], "R4");

        // R6: start with first byte right after chained bytes
        enc_byte(1'b0, 8'h33, "R3", c);
        enc_byte(1'b1, 8'h00, "R6", c);
        check(c === 8'hDA, "R6", int'(c), 'hDA);

        // R8: idle cycles hold state and output
        held = enc_out_data;
        step(1'b0, 1'b0, 8'h77, 1'b0, 1'b0, 8'h11);
        check(enc_out_valid === 1'b0, "R7", int'(enc_out_valid), 0);
        check(enc_out_data === held, "R8", int'(enc_out_data), int'(held));
        step(1'b0, 1'b0, 8'h99, 1'b0, 1'b0, 8'h22);
        check(enc_out_data === held, "R8", int'(enc_out_data), int'(held));
        enc_byte(1'b0, 8'h5A, "R8", c);

        // R9: lone start pulse reloads seeds
        step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00);
        ea = 8'h9B; eb = 8'h54; da = 8'h9B; db = 8'h54;
        check(enc_out_valid === 1'b0, "R9", int'(enc_out_valid), 0);
        enc_byte(1'b0, 8'h00, "R9", c);
        check(c === 8'hDA, "R9", int'(c), 'hDA);
        dec_byte(1'b0, 8'hDA, 8'h00, "R9");

        // R1: reset mid-packet returns to seeds
        enc_byte(1'b0, 8'h12, "R3", c);
        do_reset();
        enc_byte(1'b0, 8'h00, "R1", c);
        check(c === 8'hDA, "R1", int'(c), 'hDA);

        // R11: both lanes in the same cycle
        step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, 8'hDA);
        check(enc_out_data === 8'hDA, "R11", int'(enc_out_data), 'hDA);
        check(dec_out_data === 8'h00, "R11", int'(dec_out_data), 0);
        check(enc_out_valid && dec_out_valid, "R11", int'({enc_out_valid, dec_out_valid}), 3);
        ea = 8'h00; eb = 8'hDA; da = 8'h00; db = 8'hDA;

        // R10: random packets, lengths 1..64, including a full 64-byte packet
        for (int p = 0; p < 24; p++) begin
            int len;
            len = (p == 0) ? 64 : (p == 1) ? 1 : 1 + int'($urandom_range(63));
            for (int k = 0; k < len; k++) begin
                pbuf[k] = 8'($urandom);
                enc_byte(k == 0, pbuf[k], "R2", c);
                cbuf[k] = c;
                if ($urandom_range(3) == 0) step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
            end
            for (int k = 0; k < len; k++) begin
                dec_byte(k == 0, cbuf[k], pbuf[k], "R5");
                if ($urandom_range(3) == 0) step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule